// File: doc/BRIEF.md
# Elapsed-Time Clock with Alarm and Periodic Timer

This peripheral keeps time as a 48-bit count of ticks from a 32768 Hz enable input. The top 33 bits are whole seconds and the lowest 15 bits are the fraction of a second. Software reaches it through 16-bit words. The count is split across three words that software can both read and write. A 48-bit compare value uses the same split. When the compare value is non-zero and the count steps onto it, an alarm flag is latched.

A 32-bit periodic down-counter is loaded from a reload value. On the tick where it stands at 1, it sets its own flag and reloads. A reload value of 32768 divided by the wanted rate gives that rate. A reload value of zero stops the counter. Both flags sit in one status word, and writing ones clears them. Each flag drives a level interrupt output, gated by its own enable bit.

The block holds no snapshot latch. To get a consistent count, software reads the three time words twice and repeats until both passes agree.

Two small state machines are involved:
- The alarm machine has the states `ALM_DISARMED` and `ALM_ARMED`. A compare write that leaves a non-zero value moves it from DISARMED to ARMED. A compare write that leaves all zeros moves it from ARMED to DISARMED.
- The periodic machine has the states `PER_STOPPED` and `PER_COUNTING`. A reload write with a non-zero result moves it to COUNTING. A reload write with a zero result moves it to STOPPED. While COUNTING, a tick at count 1 triggers the expire-and-reload transition, and the machine stays in COUNTING.

Top module: `etime_rtc`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Each cycle with `tick` high and no time write adds one to the 48-bit count. The count is word 0 (bits 15:0), word 1 (bits 31:16) and word 2 (bits 47:32), and carries pass from word to word.
- R3: A write to time word 0, 1 or 2 replaces that 16-bit slice and leaves the others. In that cycle the count is not incremented even if `tick` is high.
- R4: While armed, status bit 0 (word 12) sets on the edge where a tick makes the count equal to the compare value (words 4, 5, 6). The bit is not set again on later ticks that do not match.
- R5: While all three compare words are zero, the alarm is disarmed and status bit 0 never sets, even when the count wraps to zero.
- R6: With a non-zero reload value R, the live count (words 10 and 11) steps down once per tick. On the tick where the live count is 1, it reloads R and status bit 1 sets, so the flag comes every R ticks.
- R7: A reload value of zero holds the live count at zero and never sets status bit 1.
- R8: A write to either reload half (word 8 low, word 9 high) restarts the live count at the new 32-bit reload value.
- R9: In the status word, writing 1 to bit 0 or bit 1 clears that flag. Writing 0 leaves it unchanged. Bits 2 and 3 always read zero.
- R10: When a flag sets in the same cycle that software clears it, the flag stays set.
- R11: `irq_alarm` follows status bit 0 AND enable word 13 bit 0. `irq_period` follows status bit 1 AND enable bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable at 32768 Hz |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | 16-bit word index (byte offset / 2) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_word` during a read |
| irq_alarm | output | 1 | Gated alarm interrupt level |
| irq_period | output | 1 | Gated periodic interrupt level |

## Verification
Several patterns exercise the count:
- Short tick runs from zero show the plain increment.
- Writing 0x0000_FFFF_FFFF and then ticking separates a correct word-to-word carry from a count that wraps inside a word.
- Writing all ones with the compare at zero shows that a wrap onto zero does not fire a disarmed alarm.

For the periodic timer, reload values of 3, 1 and 0x0001_0003 tell apart counters that flag a tick early or late, counters that ignore the upper half, and a single-tick period. Tick-and-write collisions separate write-over-increment priority and set-over-clear priority from the reverse orders.

// File: rtl/etime_rtc_pkg.sv
package etime_rtc_pkg;

    typedef enum logic [0:0] {ALM_DISARMED, ALM_ARMED} alm_state_e;
    typedef enum logic [0:0] {PER_STOPPED, PER_COUNTING} per_state_e;

    localparam int WORD_IDX_W = 4;

    localparam logic [WORD_IDX_W-1:0] IDX_TIME_BASE = 4'd0;
    localparam logic [WORD_IDX_W-1:0] IDX_CMP_BASE  = 4'd4;
    localparam logic [WORD_IDX_W-1:0] IDX_LOAD_BASE = 4'd8;
    localparam logic [WORD_IDX_W-1:0] IDX_LIVE_BASE = 4'd10;
    localparam logic [WORD_IDX_W-1:0] IDX_STATUS    = 4'd12;
    localparam logic [WORD_IDX_W-1:0] IDX_ENABLE    = 4'd13;

    localparam int SRC_ALARM  = 0;
    localparam int SRC_PERIOD = 1;

endpackage

// File: rtl/etime_counter.sv
module etime_counter
    import etime_rtc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WORDS  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [WORDS-1:0]         time_we,
    input  logic [WORDS-1:0]         cmp_we,
    input  logic [WORD_W-1:0]        wdata,
    output logic [WORDS*WORD_W-1:0]  count_q,
    output logic [WORDS*WORD_W-1:0]  compare_q,
    output logic                     alarm_hit
);
    localparam int CNT_W = WORDS * WORD_W;

    alm_state_e       alm_q, alm_d;
    logic [CNT_W-1:0] count_d, cmp_d, count_inc;
    logic             time_wr, cmp_wr;

    assign time_wr   = |time_we;
    assign cmp_wr    = |cmp_we;
    assign count_inc = count_q + CNT_W'(1);

    always_comb begin
        count_d = count_q;
        cmp_d   = compare_q;
        for (int w = 0; w < WORDS; w++) begin
            if (time_we[w]) count_d[w*WORD_W +: WORD_W] = wdata;
            if (cmp_we[w])  cmp_d[w*WORD_W +: WORD_W]   = wdata;
        end
        if (!time_wr && tick) count_d = count_inc;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q     <= ALM_DISARMED;
            count_q   <= '0;
            compare_q <= '0;
        end else begin
            alm_q     <= alm_d;
            count_q   <= count_d;
            compare_q <= cmp_d;
        end
    end

    // transitions
    always_comb begin
        alm_d = alm_q;
        unique case (alm_q)
            ALM_DISARMED: if (cmp_wr && cmp_d != '0) alm_d = ALM_ARMED;
            ALM_ARMED:    if (cmp_wr && cmp_d == '0) alm_d = ALM_DISARMED;
            default:      alm_d = ALM_DISARMED;
        endcase
    end

    // outputs
    always_comb begin
        alarm_hit = 1'b0;
        unique case (alm_q)
            ALM_ARMED:    alarm_hit = tick && !time_wr && (count_inc == compare_q);
            ALM_DISARMED: alarm_hit = 1'b0;
            default:      alarm_hit = 1'b0;
        endcase
    end

    p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !time_wr) |=> (count_q == $past(count_q) + CNT_W'(1)));

    for (genvar w = 0; w < WORDS; w++) begin : g_wr_chk
        p_word_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
            time_we[w] |=> (count_q[w*WORD_W +: WORD_W] == $past(wdata)));
    end

endmodule

// File: rtl/etime_periodic.sv
module etime_periodic
    import etime_rtc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [LOAD_W/WORD_W-1:0] load_we,
    input  logic [WORD_W-1:0]    wdata,
    output logic [LOAD_W-1:0]    load_q,
    output logic [LOAD_W-1:0]    live_q,
    output logic                 expire
);
    localparam int HALVES = LOAD_W / WORD_W;

    per_state_e        st_q, st_d;
    logic [LOAD_W-1:0] load_d, live_d;
    logic              restart;

    assign restart = |load_we;

    always_comb begin
        load_d = load_q;
        for (int h = 0; h < HALVES; h++)
            if (load_we[h]) load_d[h*WORD_W +: WORD_W] = wdata;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PER_STOPPED;
            load_q <= '0;
            live_q <= '0;
        end else begin
            st_q   <= st_d;
            load_q <= load_d;
            live_q <= live_d;
        end
    end

    // transitions and outputs
    always_comb begin
        st_d   = st_q;
        live_d = live_q;
        expire = 1'b0;
        if (restart) begin
            live_d = load_d;
            st_d   = (load_d != '0) ? PER_COUNTING : PER_STOPPED;
        end else begin
            unique case (st_q)
                PER_STOPPED: live_d = '0;
                PER_COUNTING: begin
                    if (tick) begin
                        if (live_q == LOAD_W'(1)) begin
                            live_d = load_q;
                            expire = 1'b1;
                        end else begin
                            live_d = live_q - LOAD_W'(1);
                        end
                    end
                end
                default: st_d = PER_STOPPED;
            endcase
        end
    end

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && st_q == PER_COUNTING && live_q == LOAD_W'(1))
        |=> (live_q == $past(load_q)));

    p_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PER_STOPPED && !restart) |=> (live_q == '0));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (live_q == load_q));

endmodule

// File: rtl/etime_irq.sv
module etime_irq #(
    parameter int SRC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SRC-1:0] set,
    input  logic           clr_we,
    input  logic           en_we,
    input  logic [SRC-1:0] wbits,
    output logic [SRC-1:0] flags_q,
    output logic [SRC-1:0] enables_q,
    output logic [SRC-1:0] irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)     enables_q <= '0;
        else if (en_we) enables_q <= wbits;
    end

    for (genvar i = 0; i < SRC; i++) begin : g_src
        logic clr_i;
        assign clr_i = clr_we && wbits[i];

        always_ff @(posedge clk) begin
            if (!rst_n)      flags_q[i] <= 1'b0;
            else if (set[i]) flags_q[i] <= 1'b1;
            else if (clr_i)  flags_q[i] <= 1'b0;
        end

        assign irq[i] = flags_q[i] & enables_q[i];

        p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set[i]) |=> !flags_q[i]);

        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_i) |=> flags_q[i]);

        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags_q[i]);
    end

endmodule

// File: rtl/etime_rtc.sv
module etime_rtc
    import etime_rtc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TIME_WORDS = 3,
    parameter int LOAD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [WORD_IDX_W-1:0] bus_word,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  irq_alarm,
    output logic                  irq_period
);
    localparam int CNT_W  = TIME_WORDS * WORD_W;
    localparam int HALVES = LOAD_W / WORD_W;
    localparam int SRC    = 2;

    logic                  wr;
    logic [TIME_WORDS-1:0] time_we, cmp_we;
    logic [HALVES-1:0]     load_we;
    logic [CNT_W-1:0]      count, compare;
    logic [LOAD_W-1:0]     load_val, live_val;
    logic                  alarm_hit, expire;
    logic [SRC-1:0]        flags, enables, irq_v;

    assign wr = bus_sel && bus_we;

    for (genvar w = 0; w < TIME_WORDS; w++) begin : g_tdec
        assign time_we[w] = wr && (bus_word == IDX_TIME_BASE + WORD_IDX_W'(w));
        assign cmp_we[w]  = wr && (bus_word == IDX_CMP_BASE + WORD_IDX_W'(w));
    end
    for (genvar h = 0; h < HALVES; h++) begin : g_ldec
        assign load_we[h] = wr && (bus_word == IDX_LOAD_BASE + WORD_IDX_W'(h));
    end

    etime_counter #(.WORD_W(WORD_W), .WORDS(TIME_WORDS)) u_counter (
        .clk, .rst_n, .tick,
        .time_we, .cmp_we, .wdata(bus_wdata),
        .count_q(count), .compare_q(compare), .alarm_hit
    );

    etime_periodic #(.WORD_W(WORD_W), .LOAD_W(LOAD_W)) u_periodic (
        .clk, .rst_n, .tick,
        .load_we, .wdata(bus_wdata),
        .load_q(load_val), .live_q(live_val), .expire
    );

    etime_irq #(.SRC(SRC)) u_irq (
        .clk, .rst_n,
        .set({expire, alarm_hit}),
        .clr_we(wr && bus_word == IDX_STATUS),
        .en_we(wr && bus_word == IDX_ENABLE),
        .wbits(bus_wdata[SRC-1:0]),
        .flags_q(flags), .enables_q(enables), .irq(irq_v)
    );

    assign irq_alarm  = irq_v[SRC_ALARM];
    assign irq_period = irq_v[SRC_PERIOD];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            for (int w = 0; w < TIME_WORDS; w++) begin
                if (bus_word == IDX_TIME_BASE + WORD_IDX_W'(w)) bus_rdata = count[w*WORD_W +: WORD_W];
                if (bus_word == IDX_CMP_BASE + WORD_IDX_W'(w))  bus_rdata = compare[w*WORD_W +: WORD_W];
            end
            for (int h = 0; h < HALVES; h++) begin
                if (bus_word == IDX_LOAD_BASE + WORD_IDX_W'(h)) bus_rdata = load_val[h*WORD_W +: WORD_W];
                if (bus_word == IDX_LIVE_BASE + WORD_IDX_W'(h)) bus_rdata = live_val[h*WORD_W +: WORD_W];
            end
            if (bus_word == IDX_STATUS) bus_rdata = WORD_W'(flags);
            if (bus_word == IDX_ENABLE) bus_rdata = WORD_W'(enables);
        end
    end

    p_alarm_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags[SRC_ALARM]) && !$past(|cmp_we) && !$past(|time_we))
        |-> (count == compare));

    p_disarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (compare == '0) |-> !alarm_hit);

    p_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!irq_alarm && !irq_period && count == '0));

endmodule

// File: tb/etime_rtc_bench.sv
module etime_rtc_bench;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_IQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 82;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 8'h00, 16'h0000, 4'd1},  // R1
        '{OP_RD, 8'h04, 16'h0000, 4'd1},
        '{OP_RD, 8'h14, 16'h0000, 4'd1},
        '{OP_RD, 8'h18, 16'h0000, 4'd1},
        '{OP_RD, 8'h1A, 16'h0000, 4'd1},
        '{OP_IQ, 8'h00, 16'h0000, 4'd1},
        '{OP_TK, 8'h00, 16'h0003, 4'd2},  // R2
        '{OP_RD, 8'h00, 16'h0003, 4'd2},
        '{OP_WR, 8'h00, 16'hFFFF, 4'd3},  // R3
        '{OP_WR, 8'h02, 16'hFFFF, 4'd3},
        '{OP_RD, 8'h02, 16'hFFFF, 4'd3},
        '{OP_TK, 8'h00, 16'h0001, 4'd2},  // R2 carry
        '{OP_RD, 8'h00, 16'h0000, 4'd2},
        '{OP_RD, 8'h02, 16'h0000, 4'd2},
        '{OP_RD, 8'h04, 16'h0001, 4'd2},
        '{OP_WR, 8'h00, 16'hFFFF, 4'd3},
        '{OP_WR, 8'h02, 16'hFFFF, 4'd3},
        '{OP_WR, 8'h04, 16'hFFFF, 4'd3},
        '{OP_TK, 8'h00, 16'h0001, 4'd5},  // R5 wrap while disarmed
        '{OP_RD, 8'h04, 16'h0000, 4'd5},
        '{OP_RD, 8'h00, 16'h0000, 4'd5},
        '{OP_RD, 8'h18, 16'h0000, 4'd5},
        '{OP_WR, 8'h08, 16'h0005, 4'd4},  // R4
        '{OP_RD, 8'h08, 16'h0005, 4'd4},
        '{OP_TK, 8'h00, 16'h0004, 4'd4},
        '{OP_RD, 8'h18, 16'h0000, 4'd4},
        '{OP_TK, 8'h00, 16'h0001, 4'd4},
        '{OP_RD, 8'h18, 16'h0001, 4'd4},
        '{OP_RD, 8'h00, 16'h0005, 4'd4},
        '{OP_IQ, 8'h00, 16'h0000, 4'd11}, // R11
        '{OP_WR, 8'h1A, 16'h0001, 4'd11},
        '{OP_IQ, 8'h00, 16'h0001, 4'd11},
        '{OP_WR, 8'h18, 16'h0000, 4'd9},  // R9
        '{OP_RD, 8'h18, 16'h0001, 4'd9},
        '{OP_WR, 8'h18, 16'h000E, 4'd9},
        '{OP_RD, 8'h18, 16'h0001, 4'd9},
        '{OP_WR, 8'h18, 16'h0001, 4'd9},
        '{OP_RD, 8'h18, 16'h0000, 4'd9},
        '{OP_IQ, 8'h00, 16'h0000, 4'd11},
        '{OP_TK, 8'h00, 16'h0001, 4'd4},
        '{OP_RD, 8'h18, 16'h0000, 4'd4},
        '{OP_WR, 8'h08, 16'h0000, 4'd5},  // R5 disarm
        '{OP_WR, 8'h00, 16'h0004, 4'd5},
        '{OP_TK, 8'h00, 16'h0001, 4'd5},
        '{OP_RD, 8'h18, 16'h0000, 4'd5},
        '{OP_WR, 8'h02, 16'h1234, 4'd3},
        '{OP_RD, 8'h02, 16'h1234, 4'd3},
        '{OP_RD, 8'h00, 16'h0005, 4'd3},
        '{OP_WR, 8'h10, 16'h0003, 4'd6},  // R6
        '{OP_RD, 8'h14, 16'h0003, 4'd6},
        '{OP_TK, 8'h00, 16'h0002, 4'd6},
        '{OP_RD, 8'h14, 16'h0001, 4'd6},
        '{OP_RD, 8'h18, 16'h0000, 4'd6},
        '{OP_TK, 8'h00, 16'h0001, 4'd6},
        '{OP_RD, 8'h14, 16'h0003, 4'd6},
        '{OP_RD, 8'h18, 16'h0002, 4'd6},
        '{OP_WR, 8'h1A, 16'h0002, 4'd11},
        '{OP_IQ, 8'h00, 16'h0002, 4'd11},
        '{OP_WR, 8'h18, 16'h0002, 4'd9},
        '{OP_RD, 8'h18, 16'h0000, 4'd9},
        '{OP_TK, 8'h00, 16'h0003, 4'd6},
        '{OP_RD, 8'h18, 16'h0002, 4'd6},
        '{OP_WR, 8'h18, 16'h0002, 4'd9},
        '{OP_WR, 8'h12, 16'h0001, 4'd8},  // R8
        '{OP_RD, 8'h14, 16'h0003, 4'd8},
        '{OP_RD, 8'h16, 16'h0001, 4'd8},
        '{OP_TK, 8'h00, 16'h0001, 4'd8},
        '{OP_RD, 8'h14, 16'h0002, 4'd8},
        '{OP_WR, 8'h10, 16'h0007, 4'd8},
        '{OP_RD, 8'h14, 16'h0007, 4'd8},
        '{OP_RD, 8'h16, 16'h0001, 4'd8},
        '{OP_WR, 8'h12, 16'h0000, 4'd7},  // R7
        '{OP_WR, 8'h10, 16'h0000, 4'd7},
        '{OP_RD, 8'h14, 16'h0000, 4'd7},
        '{OP_RD, 8'h16, 16'h0000, 4'd7},
        '{OP_TK, 8'h00, 16'h0005, 4'd7},
        '{OP_RD, 8'h14, 16'h0000, 4'd7},
        '{OP_RD, 8'h18, 16'h0000, 4'd7},
        '{OP_WR, 8'h10, 16'h0001, 4'd6},  // R6 single-tick period
        '{OP_TK, 8'h00, 16'h0001, 4'd6},
        '{OP_RD, 8'h18, 16'h0002, 4'd6},
        '{OP_RD, 8'h14, 16'h0001, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_word = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_alarm, irq_period;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    etime_rtc u_etime_rtc (
        .clk, .rst_n, .tick, .bus_sel, .bus_we, .bus_word,
        .bus_wdata, .bus_rdata, .irq_alarm, .irq_period
    );

    task automatic check(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic with_tick);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = a[4:1]; bus_wdata = d; tick = with_tick;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input int req);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = a[4:1];
        #1;
        check(req, $sformatf("read word 0x%02h", a), bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic irqs(input logic [1:0] exp, input int req);
        @(negedge clk);
        #1;
        check(req, "irq {period,alarm}", {14'd0, irq_period, irq_alarm}, {14'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                OP_WR: wr(VEC[i].addr, VEC[i].data, 1'b0);
                OP_RD: rd(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
                OP_TK: ticks(int'(VEC[i].data));
                OP_IQ: irqs(VEC[i].data[1:0], int'(VEC[i].req));
                default: ;
            endcase
        end

        // R3: write wins over a tick in the same cycle
        wr(8'h10, 16'h0000, 1'b0);
        wr(8'h18, 16'h0003, 1'b0);
        wr(8'h00, 16'h0100, 1'b1);
        rd(8'h00, 16'h0100, 3);
        rd(8'h02, 16'h1234, 3);

        // R10: alarm match and status clear in the same cycle
        wr(8'h08, 16'h0101, 1'b0);
        wr(8'h0A, 16'h1234, 1'b0);
        wr(8'h18, 16'h0001, 1'b1);
        rd(8'h18, 16'h0001, 10);
        rd(8'h00, 16'h0101, 10);
        irqs(2'b00, 11);

        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, 16'h0000, 1);
        rd(8'h02, 16'h0000, 1);
        rd(8'h08, 16'h0000, 1);
        rd(8'h10, 16'h0000, 1);
        rd(8'h18, 16'h0000, 1);
        rd(8'h1A, 16'h0000, 1);
        irqs(2'b00, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule